// File: doc/BRIEF.md
# UART Register File with Busy-Guarded Line Control

This block is the software-visible register layer of a 16550-style serial port. A simple single-cycle register bus (select, write strobe, word address, write data, combinational read data) reaches the data port, interrupt enable, interrupt identity, FIFO control, line control, modem control, line status, scratch and a separate UART status register. The serial shifters, FIFOs and baud generator sit outside. They report their activity to this block on status inputs and receive strobes and the stored configuration from it.

The distinguishing feature is a guarded line control register. In guarded mode (`COMPAT = 0`) the block drops any line control write that arrives while serial traffic is in progress. It then raises a busy-detect interrupt, which stays pending until software reads the status register. Software confirms a write by reading line control back. If the write was dropped, software resets the FIFOs and reads the receive buffer to bring the port to idle, then writes again. Setting `COMPAT = 1` gives the plain behaviour, in which line control is always writable.

Top module: `uart_regfile_lock`

## Requirements
- R1: After reset, line control reads 0x00, the interrupt identity reads 0x01, the status register (word 31) reads 0x00 with the port idle, and `irq` is low.
- R2: With `COMPAT = 0`, a write to line control (word 3) is discarded while busy. Busy means any of these holds: `tx_shift_active` is high, `tx_fifo_empty` is low, `rx_frame_active` is high, or `rx_data_avail` is high. A read of line control then still returns the earlier value.
- R3: A discarded line control write sets a pending busy-detect condition. The low nibble of the interrupt identity (word 2) then reads 4'b0111 and `irq` goes high. This identity is not masked by the enable register.
- R4: A read of the status register clears the pending busy-detect condition. Bit 0 of that read returns the current busy state.
- R5: With the port idle, a line control write takes effect on the next cycle, and all eight bits read back as written, including bit 5 (stick parity) and bit 7 (divisor access).
- R6: A write to word 2 pulses `rx_fifo_clr` when data bit 1 is set and `tx_fifo_clr` when data bit 2 is set, and bit 0 is stored as the FIFO-enable flag. A read of word 0 with bit 7 of line control clear returns `rx_data` and pulses `rx_pop`. After these drain steps, the next line control write is accepted.
- R7: While bit 7 of line control is set, words 0 and 1 read and write the low and high bytes of `baud_div`, and no `tx_push` or `rx_pop` occurs. While it is clear, a write to word 0 pulses `tx_push` with `tx_data` equal to the written byte, and word 1 is the 4-bit interrupt enable.
- R8: The interrupt identity low nibble follows a fixed priority, from highest to lowest: line error 0110 (enable bit 2, any `rx_err` bit), receive data 0100 (enable bit 0), receive timeout 1100 (enable bit 0), transmit empty 0010 (enable bit 1), busy-detect 0111. With nothing pending it reads 0001. Bits 7:6 read 11 when the FIFO-enable flag is set.
- R9: With `COMPAT = 1`, line control writes are accepted while busy, and the busy-detect interrupt never becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| tx_shift_active | input | 1 | Transmit shifter is sending |
| tx_fifo_empty | input | 1 | Transmit FIFO holds nothing |
| rx_frame_active | input | 1 | Receiver is inside a frame |
| rx_data_avail | input | 1 | Receive FIFO holds unread data |
| rx_timeout | input | 1 | Receive character timeout |
| rx_err | input | 4 | Receive error flags (overrun, parity, framing, break) |
| rx_data | input | DATA_W | Head of receive FIFO |
| tx_push | output | 1 | Push `tx_data` into transmit FIFO |
| tx_data | output | DATA_W | Transmit byte |
| rx_pop | output | 1 | Pop receive FIFO |
| tx_fifo_clr | output | 1 | Clear transmit FIFO |
| rx_fifo_clr | output | 1 | Clear receive FIFO |
| line_cfg | output | DATA_W | Stored line control value |
| baud_div | output | 2*DATA_W | Baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
A wrong lock state appears at the ports one cycle after a line control write. Line control either reads back a value it should have dropped or keeps a value it should have taken, and `line_cfg` shows the same result at once. A pending-flag error shows at the next identity read, as a 0111 that does not clear after a status read or a missing one after a rejected write. Divisor-steering errors show as a `tx_push` or `rx_pop` pulse in the same cycle as the access. A wrong priority shows as a wrong identity code as each source is withdrawn in turn.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  typedef enum logic [3:0] {
    IID_NONE = 4'b0001,
    IID_THRE = 4'b0010,
    IID_RXD  = 4'b0100,
    IID_LINE = 4'b0110,
    IID_BUSY = 4'b0111,
    IID_TMO  = 4'b1100
  } iid_e;

  localparam int IER_W    = 4;
  localparam int RXERR_W  = 4;
  localparam int MCR_W    = 5;
  localparam int DLAB_BIT = 7;

endpackage

// File: rtl/uart_rf_busy.sv
module uart_rf_busy #(
  parameter bit COMPAT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_shift_active,
  input  logic tx_fifo_empty,
  input  logic rx_frame_active,
  input  logic rx_data_avail,
  input  logic lcr_wr,
  input  logic usr_rd,
  output logic busy,
  output logic lcr_en,
  output logic busy_irq
);

  always_comb begin
    busy = tx_shift_active | ~tx_fifo_empty | rx_frame_active | rx_data_avail;
  end

  generate
    if (COMPAT) begin : g_open
      always_comb begin
        lcr_en   = lcr_wr;
        busy_irq = 1'b0;
      end
    end else begin : g_guard
      logic pend_q;
      logic pend_d;

      always_comb begin
        lcr_en = lcr_wr & ~busy;
        pend_d = pend_q;
        if (lcr_wr && busy) begin
          pend_d = 1'b1;
        end else if (usr_rd) begin
          pend_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
        end else begin
          pend_q <= pend_d;
        end
      end

      always_comb begin
        busy_irq = pend_q;
      end

      AST_REJECT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_wr && busy) |=> busy_irq); // R3
      AST_USR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        usr_rd |=> !busy_irq); // R4
    end
  endgenerate

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic [IER_W-1:0] ier,
  input  logic             rx_err_any,
  input  logic             rx_data_avail,
  input  logic             rx_timeout,
  input  logic             tx_fifo_empty,
  input  logic             busy_irq,
  output iid_e             iid,
  output logic             irq
);

  always_comb begin
    if (ier[2] && rx_err_any) begin
      iid = IID_LINE;
    end else if (ier[0] && rx_data_avail) begin
      iid = IID_RXD;
    end else if (ier[0] && rx_timeout) begin
      iid = IID_TMO;
    end else if (ier[1] && tx_fifo_empty) begin
      iid = IID_THRE;
    end else if (busy_irq) begin
      iid = IID_BUSY;
    end else begin
      iid = IID_NONE;
    end
    irq = (iid != IID_NONE);
  end

endmodule

// File: rtl/uart_regfile_lock.sv
module uart_regfile_lock
  import uart_rf_pkg::*;
#(
  parameter bit COMPAT = 1'b0,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                tx_shift_active,
  input  logic                tx_fifo_empty,
  input  logic                rx_frame_active,
  input  logic                rx_data_avail,
  input  logic                rx_timeout,
  input  logic [RXERR_W-1:0]  rx_err,
  input  logic [DATA_W-1:0]   rx_data,
  output logic                tx_push,
  output logic [DATA_W-1:0]   tx_data,
  output logic                rx_pop,
  output logic                tx_fifo_clr,
  output logic                rx_fifo_clr,
  output logic [DATA_W-1:0]   line_cfg,
  output logic [2*DATA_W-1:0] baud_div,
  output logic                irq
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IIR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LCR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MCR  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_LSR  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_USR  = ADDR_W'(31);

  logic [DATA_W-1:0] lcr_q, lcr_d, dll_q, dll_d, dlh_q, dlh_d, scr_q, scr_d;
  logic [IER_W-1:0]  ier_q, ier_d;
  logic [MCR_W-1:0]  mcr_q, mcr_d;
  logic              fen_q, fen_d;

  logic wr_hit, rd_hit, dlab;
  logic lcr_wr, usr_rd, lcr_en, busy, busy_irq;
  logic dll_wr, dlh_wr, ier_wr, fcr_wr, mcr_wr, scr_wr;
  iid_e iid;

  always_comb begin
    wr_hit = bus_sel & bus_wr;
    rd_hit = bus_sel & ~bus_wr;
    dlab   = lcr_q[DLAB_BIT];
    lcr_wr = wr_hit & (bus_addr == A_LCR);
    usr_rd = rd_hit & (bus_addr == A_USR);
    dll_wr = wr_hit & (bus_addr == A_DATA) & dlab;
    dlh_wr = wr_hit & (bus_addr == A_IER) & dlab;
    ier_wr = wr_hit & (bus_addr == A_IER) & ~dlab;
    fcr_wr = wr_hit & (bus_addr == A_IIR);
    mcr_wr = wr_hit & (bus_addr == A_MCR);
    scr_wr = wr_hit & (bus_addr == A_SCR);
    tx_push     = wr_hit & (bus_addr == A_DATA) & ~dlab;
    tx_data     = bus_wdata;
    rx_pop      = rd_hit & (bus_addr == A_DATA) & ~dlab;
    rx_fifo_clr = fcr_wr & bus_wdata[1];
    tx_fifo_clr = fcr_wr & bus_wdata[2];
  end

  uart_rf_busy #(.COMPAT(COMPAT)) u_busy (
    .clk             (clk),
    .rst_n           (rst_n),
    .tx_shift_active (tx_shift_active),
    .tx_fifo_empty   (tx_fifo_empty),
    .rx_frame_active (rx_frame_active),
    .rx_data_avail   (rx_data_avail),
    .lcr_wr          (lcr_wr),
    .usr_rd          (usr_rd),
    .busy            (busy),
    .lcr_en          (lcr_en),
    .busy_irq        (busy_irq)
  );

  uart_rf_irq u_irq (
    .ier           (ier_q),
    .rx_err_any    (|rx_err),
    .rx_data_avail (rx_data_avail),
    .rx_timeout    (rx_timeout),
    .tx_fifo_empty (tx_fifo_empty),
    .busy_irq      (busy_irq),
    .iid           (iid),
    .irq           (irq)
  );

  always_comb begin
    lcr_d = lcr_en ? bus_wdata : lcr_q;
    dll_d = dll_wr ? bus_wdata : dll_q;
    dlh_d = dlh_wr ? bus_wdata : dlh_q;
    ier_d = ier_wr ? bus_wdata[IER_W-1:0] : ier_q;
    mcr_d = mcr_wr ? bus_wdata[MCR_W-1:0] : mcr_q;
    scr_d = scr_wr ? bus_wdata : scr_q;
    fen_d = fcr_wr ? bus_wdata[0] : fen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0;
      dll_q <= '0;
      dlh_q <= '0;
      ier_q <= '0;
      mcr_q <= '0;
      scr_q <= '0;
      fen_q <= 1'b0;
    end else begin
      lcr_q <= lcr_d;
      dll_q <= dll_d;
      dlh_q <= dlh_d;
      ier_q <= ier_d;
      mcr_q <= mcr_d;
      scr_q <= scr_d;
      fen_q <= fen_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA:  bus_rdata = dlab ? dll_q : rx_data;
      A_IER:   bus_rdata = dlab ? dlh_q : DATA_W'(ier_q);
      A_IIR:   bus_rdata = DATA_W'({fen_q, fen_q, 2'b00, iid});
      A_LCR:   bus_rdata = lcr_q;
      A_MCR:   bus_rdata = DATA_W'(mcr_q);
      A_LSR:   bus_rdata = DATA_W'({1'b0, tx_fifo_empty & ~tx_shift_active,
                                    tx_fifo_empty, rx_err, rx_data_avail});
      A_SCR:   bus_rdata = scr_q;
      A_USR:   bus_rdata = DATA_W'(busy);
      default: bus_rdata = '0;
    endcase
    line_cfg = lcr_q;
    baud_div = {dlh_q, dll_q};
  end

  AST_LCR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!COMPAT && lcr_wr && busy) |=> $stable(lcr_q)); // R2
  AST_LCR_TAKEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_wr && !busy) |=> (lcr_q == $past(bus_wdata))); // R5
  AST_DIV_NO_DATAPATH: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_wr || dlh_wr) |-> !(tx_push || rx_pop)); // R7

endmodule

// File: tb/sim_uart_regfile_lock.sv
module sim_uart_regfile_lock;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        tx_shift_active = 1'b0, tx_fifo_empty = 1'b1;
  logic        rx_frame_active = 1'b0, rx_data_avail = 1'b0, rx_timeout = 1'b0;
  logic [3:0]  rx_err = '0;
  logic [7:0]  rx_data = '0;

  logic [7:0]  rd0, rd1, tx_data0, tx_data1, lcr0, lcr1;
  logic [15:0] div0, div1;
  logic        tx_push0, rx_pop0, txclr0, rxclr0, irq0;
  logic        tx_push1, rx_pop1, txclr1, rxclr1, irq1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] r0, r1;

  always #2.5 clk = ~clk;

  uart_regfile_lock #(.COMPAT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0),
    .tx_shift_active(tx_shift_active), .tx_fifo_empty(tx_fifo_empty),
    .rx_frame_active(rx_frame_active), .rx_data_avail(rx_data_avail),
    .rx_timeout(rx_timeout), .rx_err(rx_err), .rx_data(rx_data),
    .tx_push(tx_push0), .tx_data(tx_data0), .rx_pop(rx_pop0),
    .tx_fifo_clr(txclr0), .rx_fifo_clr(rxclr0), .line_cfg(lcr0),
    .baud_div(div0), .irq(irq0));

  uart_regfile_lock #(.COMPAT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1),
    .tx_shift_active(tx_shift_active), .tx_fifo_empty(tx_fifo_empty),
    .rx_frame_active(rx_frame_active), .rx_data_avail(rx_data_avail),
    .rx_timeout(rx_timeout), .rx_err(rx_err), .rx_data(rx_data),
    .tx_push(tx_push1), .tx_data(tx_data1), .rx_pop(rx_pop1),
    .tx_fifo_clr(txclr1), .rx_fifo_clr(rxclr1), .line_cfg(lcr1),
    .baud_div(div1), .irq(irq1));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    r0 = rd0; r1 = rd1;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic set_src(input int k, input logic on);
    case (k)
      0: tx_shift_active = on;
      1: tx_fifo_empty   = ~on;
      2: rx_frame_active = on;
      default: rx_data_avail = on;
    endcase
  endtask

  task automatic t_reset;
    bus_read(5'd3);  check("R1 lcr", r0, 8'h00);
    bus_read(5'd2);  check("R1 iir", r0, 8'h01);
    bus_read(5'd31); check("R1 usr", r0, 8'h00);
    check("R1 irq", irq0, 1'b0);
  endtask

  task automatic t_idle_lcr;
    bus_write(5'd3, 8'hBF);
    bus_read(5'd3);  check("R5 lcr bits 5 and 7", r0, 8'hBF);
    check("R5 line_cfg", lcr0, 8'hBF);
    bus_write(5'd3, 8'h03);
    bus_read(5'd3);  check("R5 lcr 03", r0, 8'h03);
  endtask

  task automatic t_busy_reject;
    for (int k = 0; k < 4; k++) begin
      set_src(k, 1'b1);
      bus_write(5'd3, 8'h1B);
      bus_read(5'd3);  check("R2 lcr kept", r0, 8'h03);
      check("R9 compat lcr taken", r1, 8'h1B);
      check("R3 irq", irq0, 1'b1);
      check("R9 compat irq", irq1, 1'b0);
      bus_read(5'd2);  check("R3 iir busy", r0, 8'h07);
      check("R9 compat iir", r1, 8'h01);
      bus_read(5'd31); check("R4 usr busy bit", r0, 8'h01);
      bus_read(5'd2);  check("R4 iir cleared", r0, 8'h01);
      check("R4 irq cleared", irq0, 1'b0);
      set_src(k, 1'b0);
    end
  endtask

  task automatic t_drain;
    rx_data = 8'hA5; rx_data_avail = 1'b1; tx_fifo_empty = 1'b0;
    bus_write(5'd3, 8'h07);
    bus_read(5'd3);  check("R2 lcr kept before drain", r0, 8'h03);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'd2; bus_wdata = 8'h07;
    #1;
    check("R6 rx clr", rxclr0, 1'b1);
    check("R6 tx clr", txclr0, 1'b1);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    tx_fifo_empty = 1'b1;
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = 5'd0;
    #1;
    check("R6 rbr data", rd0, 8'hA5);
    check("R6 rx pop", rx_pop0, 1'b1);
    @(negedge clk);
    bus_sel = 1'b0;
    rx_data_avail = 1'b0;
    bus_read(5'd31); check("R4 usr idle", r0, 8'h00);
    bus_write(5'd3, 8'h07);
    bus_read(5'd3);  check("R6 lcr after drain", r0, 8'h07);
  endtask

  task automatic t_dlab;
    bus_write(5'd3, 8'h83);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'd0; bus_wdata = 8'h34;
    #1;
    check("R7 no push under dlab", tx_push0, 1'b0);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_write(5'd1, 8'h12);
    check("R7 divisor", div0, 16'h1234);
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = 5'd0;
    #1;
    check("R7 dll read", rd0, 8'h34);
    check("R7 no pop under dlab", rx_pop0, 1'b0);
    @(negedge clk);
    bus_sel = 1'b0;
    bus_write(5'd3, 8'h03);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'd0; bus_wdata = 8'h55;
    #1;
    check("R7 tx push", tx_push0, 1'b1);
    check("R7 tx data", tx_data0, 8'h55);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_write(5'd1, 8'h05);
    bus_read(5'd1);  check("R7 ier read", r0, 8'h05);
    check("R7 divisor unchanged", div0, 16'h1234);
  endtask

  task automatic t_prio;
    bus_write(5'd1, 8'h07);
    rx_err = 4'b0010; rx_data_avail = 1'b1; rx_timeout = 1'b1; tx_fifo_empty = 1'b1;
    bus_write(5'd3, 8'h00);
    bus_read(5'd2);  check("R8 line first", r0, 8'hC6);
    rx_err = '0;
    bus_read(5'd2);  check("R8 rx data", r0, 8'hC4);
    rx_data_avail = 1'b0;
    bus_read(5'd2);  check("R8 timeout", r0, 8'hCC);
    rx_timeout = 1'b0;
    bus_read(5'd2);  check("R8 thr empty", r0, 8'hC2);
    bus_write(5'd1, 8'h00);
    bus_read(5'd2);  check("R8 busy last", r0, 8'hC7);
    check("R3 irq unmasked", irq0, 1'b1);
    bus_read(5'd31); check("R4 usr idle", r0, 8'h00);
    bus_read(5'd2);  check("R8 none", r0, 8'hC1);
    check("R4 irq low", irq0, 1'b0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_lcr();
    t_busy_reject();
    t_drain();
    t_dlab();
    t_prio();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule